// File: doc/BRIEF.md
# Dual-Compare Single-Shot Pulse Generator

This block is one timer channel that produces a single output pulse by watching an external 16-bit free-running counter bus. Two comparators each hold a programmed match value. When the counter equals the first value the pin moves to its leading level. When it equals the second value the pin moves to the opposite, trailing level. Each comparator is armed by a write to its data register and disarms itself after one match, so every pulse is requested explicitly by software.

Software uses a small write port with four addresses: the leading-edge match value, the trailing-edge match value, a control word and a status word. The control word holds a 4-bit mode, the leading-edge level and a port level. A sticky flag output reports match events and is cleared by software. The block can make a full pulse (both values written), a single transition (one value written), or drive the pin as a plain output bit when no compare is armed.

Top module: `oc_pulse_gen`

## Requirements
- R1: After reset `pin_out` is 0, `flag_out` is 0, both comparators are disarmed and the control word is all zeros (mode 0000, disabled).
- R2: When the leading comparator is armed and `cnt_bus` equals its value, `pin_out` takes the leading level (control bit 4) at the clock edge where the equality is sampled, visible in the following cycle.
- R3: When the trailing comparator is armed and `cnt_bus` equals its value, `pin_out` takes the inverse of control bit 4 with the same timing as R2.
- R4: A comparator is armed only by a write to its data register (address 0 leading, address 1 trailing) and disarms after its first match; a later equal counter value causes no edge.
- R5: With mode 0100 the flag is set only by a trailing-comparator match; a leading match leaves it clear.
- R6: With mode 0101 the flag is set by a match on either comparator.
- R7: The flag is sticky. A write to address 3 with bit 0 = 0 clears it; bit 0 = 1 leaves it unchanged. A match event in the same cycle as the clear keeps the flag set.
- R8: If both comparators match in the same cycle, the pin ends at the trailing level.
- R9: A control write (address 2) made while both comparators are disarmed loads control bit 5 onto `pin_out`; while either comparator is armed the port bit does not change the pin.
- R10: Only modes 0100 and 0101 (control bits 3:0) enable comparison. In any other mode data writes arm nothing and nothing matches; on entering the compare mode both comparators start disarmed.
- R11: Writing a data register while its comparator is armed replaces the match value; the old value no longer produces an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_bus | input | 16 | Selected free-running counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 leading value, 1 trailing value, 2 control, 3 status |
| wr_data | input | 16 | Write data |
| pin_out | output | 1 | Registered pulse output pin |
| flag_out | output | 1 | Registered sticky match flag |

## Verification
The hardest case to reach from the ports is a flag clear landing in exactly the cycle of a trailing match, where the set must win over the clear. The bench arms the trailing comparator with the counter parked elsewhere, then in a single cycle drives the counter onto the armed value and issues the clearing status write together. Equally narrow are the simultaneous match of both comparators and the port-level write that must be ignored while a compare is armed; each is reached by holding the counter still and writing registers one cycle at a time.

// File: rtl/oc_pulse_pkg.sv
package oc_pulse_pkg;

    localparam int MODE_W = 4;

    localparam logic [1:0] ADDR_LEAD  = 2'd0;
    localparam logic [1:0] ADDR_TRAIL = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

    localparam logic [2:0] OC_MODE_TOP = 3'b010;

    localparam int CTRL_W = MODE_W + 2;

    typedef struct packed {
        logic              port_lvl;
        logic              lead_lvl;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic logic mode_is_oc(input logic [MODE_W-1:0] m);
        return m[MODE_W-1:1] == OC_MODE_TOP;
    endfunction

endpackage

// File: rtl/oc_cmp_chan.sv
module oc_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cnt,
    output logic         hit,
    output logic         armed
);

    typedef struct packed {
        logic         armed;
        logic [W-1:0] val;
    } chan_t;

    chan_t chan_d, chan_q;
    logic  hit_now;

    always_comb begin
        chan_d  = chan_q;
        hit_now = enable && chan_q.armed && (cnt == chan_q.val);
        if (load) begin
            chan_d.val = load_val;
        end
        if (!enable) begin
            chan_d.armed = 1'b0;
        end else if (load) begin
            chan_d.armed = 1'b1;
        end else if (hit_now) begin
            chan_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign hit   = hit_now;
    assign armed = chan_q.armed;

    assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load) |=> !armed);

    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !armed);

    assert_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load) |=> (armed && chan_q.val == $past(load_val)));

endmodule

// File: rtl/oc_out_ctl.sv
module oc_out_ctl
    import oc_pulse_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         hit_lead,
    input  logic         hit_trail,
    input  logic         armed_lead,
    input  logic         armed_trail,
    output logic         oc_en,
    output logic         pin,
    output logic         flag
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  pin;
        logic  flag;
    } out_t;

    out_t  out_d, out_q;
    ctrl_t wr_ctrl;
    logic  ctrl_wr;
    logic  stat_clr;
    logic  flag_ev;
    logic  unused_hi;

    assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign unused_hi = ^wr_data[W-1:CTRL_W];

    always_comb begin
        out_d    = out_q;
        ctrl_wr  = wr_en && (wr_sel == ADDR_CTRL);
        stat_clr = wr_en && (wr_sel == ADDR_STAT) && !wr_data[0];
        flag_ev  = hit_trail || (out_q.ctrl.mode[0] && hit_lead);

        if (ctrl_wr) begin
            out_d.ctrl = wr_ctrl;
        end

        out_d.flag = flag_ev || (out_q.flag && !stat_clr);

        if (hit_trail) begin
            out_d.pin = !out_q.ctrl.lead_lvl;
        end else if (hit_lead) begin
            out_d.pin = out_q.ctrl.lead_lvl;
        end else if (ctrl_wr && !armed_lead && !armed_trail) begin
            out_d.pin = wr_ctrl.port_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign oc_en = mode_is_oc(out_q.ctrl.mode);
    assign pin   = out_q.pin;
    assign flag  = out_q.flag;

    assert_lead_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lead && !hit_trail) |=> (pin == $past(out_q.ctrl.lead_lvl)));

    assert_trail_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_trail |=> (pin == !$past(out_q.ctrl.lead_lvl)));

    assert_trail_only_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q.ctrl.mode[0] && !hit_trail && !flag) |=> !flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_sel == ADDR_STAT && !wr_data[0])) |=> flag);

    assert_port_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((armed_lead || armed_trail) && !hit_lead && !hit_trail) |=> $stable(pin));

endmodule

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen
    import oc_pulse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_bus,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pin_out,
    output logic             flag_out
);

    localparam int NCH = 2;
    localparam int CH_LEAD  = 0;
    localparam int CH_TRAIL = 1;

    logic [NCH-1:0] ch_load;
    logic [NCH-1:0] ch_hit;
    logic [NCH-1:0] ch_armed;
    logic           oc_en;

    assign ch_load[CH_LEAD]  = wr_en && (wr_sel == ADDR_LEAD);
    assign ch_load[CH_TRAIL] = wr_en && (wr_sel == ADDR_TRAIL);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        oc_cmp_chan #(.W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (oc_en),
            .load     (ch_load[i]),
            .load_val (wr_data),
            .cnt      (cnt_bus),
            .hit      (ch_hit[i]),
            .armed    (ch_armed[i])
        );
    end

    oc_out_ctl #(.W(CNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .hit_lead    (ch_hit[CH_LEAD]),
        .hit_trail   (ch_hit[CH_TRAIL]),
        .armed_lead  (ch_armed[CH_LEAD]),
        .armed_trail (ch_armed[CH_TRAIL]),
        .oc_en       (oc_en),
        .pin         (pin_out),
        .flag        (flag_out)
    );

    assert_hits_only_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_en |-> (ch_hit == '0));

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pin_out && !flag_out));

endmodule

// File: tb/oc_pulse_gen_bench.sv
module oc_pulse_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_bus = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         pin_out;
    logic         flag_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_pulse_gen #(.CNT_W(W)) u_oc_pulse_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_bus  (cnt_bus),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pin_out  (pin_out),
        .flag_out (flag_out)
    );

    // control word: bit5 port level, bit4 leading level, bits3:0 mode
    function automatic logic [W-1:0] ctrl_word(input logic port, input logic lead, input logic [3:0] mode);
        return {{(W-6){1'b0}}, port, lead, mode};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [W-1:0] c);
        @(negedge clk);
        cnt_bus = c;
        @(posedge clk);
        @(negedge clk);
        cnt_bus = '0;
    endtask

    task automatic t_reset;
        chk("R1 pin after reset", pin_out, 1'b0);
        chk("R1 flag after reset", flag_out, 1'b0);
    endtask

    task automatic t_disabled;
        wr(2'd0, 16'h0010);                 // mode 0000: must not arm
        wr(2'd2, ctrl_word(1'b0, 1'b1, 4'b0101));
        step(16'h0010);
        chk("R10 no edge from write made while disabled", pin_out, 1'b0);
        chk("R10 no flag from write made while disabled", flag_out, 1'b0);
    endtask

    task automatic t_pulse;
        wr(2'd2, ctrl_word(1'b0, 1'b1, 4'b0100));
        wr(2'd0, 16'h0020);
        wr(2'd1, 16'h0030);
        step(16'h0020);
        chk("R2 leading edge level", pin_out, 1'b1);
        chk("R5 no flag on leading match", flag_out, 1'b0);
        step(16'h0030);
        chk("R3 trailing edge level", pin_out, 1'b0);
        chk("R5 flag on trailing match", flag_out, 1'b1);
        step(16'h0020);
        chk("R4 no second leading edge", pin_out, 1'b0);
    endtask

    task automatic t_clear;
        wr(2'd3, 16'h0001);
        chk("R7 write of one keeps flag", flag_out, 1'b1);
        wr(2'd3, 16'h0000);
        chk("R7 write of zero clears flag", flag_out, 1'b0);
        wr(2'd1, 16'h0040);
        @(negedge clk);
        cnt_bus = 16'h0040; wr_en = 1'b1; wr_sel = 2'd3; wr_data = '0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; cnt_bus = '0;
        chk("R7 match beats simultaneous clear", flag_out, 1'b1);
    endtask

    task automatic t_port;
        wr(2'd3, 16'h0000);
        wr(2'd2, ctrl_word(1'b1, 1'b1, 4'b0100));
        chk("R9 port level loaded when idle", pin_out, 1'b1);
        wr(2'd0, 16'h0050);
        wr(2'd2, ctrl_word(1'b0, 1'b0, 4'b0100));
        chk("R9 port level ignored while armed", pin_out, 1'b1);
        step(16'h0050);
        chk("R2 leading level low", pin_out, 1'b0);
        chk("R5 leading match leaves flag clear", flag_out, 1'b0);
    endtask

    task automatic t_either;
        wr(2'd2, ctrl_word(1'b0, 1'b1, 4'b0101));
        chk("R9 port low loaded when idle", pin_out, 1'b0);
        wr(2'd0, 16'h0058);
        step(16'h0058);
        chk("R2 leading edge in either mode", pin_out, 1'b1);
        chk("R6 flag on leading match", flag_out, 1'b1);
    endtask

    task automatic t_both;
        wr(2'd3, 16'h0000);
        wr(2'd2, ctrl_word(1'b1, 1'b1, 4'b0101));
        chk("R9 port high before dual match", pin_out, 1'b1);
        wr(2'd0, 16'h0060);
        wr(2'd1, 16'h0060);
        step(16'h0060);
        chk("R8 trailing wins on dual match", pin_out, 1'b0);
        chk("R6 flag on dual match", flag_out, 1'b1);
    endtask

    task automatic t_rewrite;
        wr(2'd0, 16'h0070);
        wr(2'd0, 16'h0075);
        step(16'h0070);
        chk("R11 old value gives no edge", pin_out, 1'b0);
        step(16'h0075);
        chk("R11 new value gives edge", pin_out, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_pulse();
        t_clear();
        t_port();
        t_either();
        t_both();
        t_rewrite();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule